// File: doc/BRIEF.md
# UART DMA Ready-Signal Generator

This block drives the two active-low handshake lines that one UART channel offers to a DMA controller: a receive-ready line and a transmit-ready line. It watches the channel's mode bits, the fill levels of the 16-entry receive and transmit FIFOs, a two-bit receive trigger selection, a receive-timeout pulse and a receive-FIFO clear pulse. When the FIFOs are off, it looks at the one-byte holding-register flags instead of the fill levels.

Three modes give the outputs different meanings. In byte mode (FIFO enable low), the lines follow the holding-register flags. In stream mode (FIFO enable high, DMA-mode bit low), receive-ready means "any data present" and transmit-ready means "transmit FIFO completely empty". In block mode (both bits high), transmit-ready means "room for at least one byte". Receive-ready works as a latch in block mode. It falls when the receive fill reaches the trigger level or when a timeout arrives. It rises again only once the FIFO has fully drained.

The block-mode latch is a two-state machine. RX_IDLE moves to RX_HELD on *arm* (trigger reached or timeout, while block mode is armed). RX_HELD moves back to RX_IDLE on *drain* (fill count zero) or on *disarm* (mode not block, mode changed this cycle, or receive-FIFO clear). Both outputs are registered.

Top module: `uart_dma_ready_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, rxrdy_n and txrdy_n are both 1 and the latch is in RX_IDLE.
- R2: Byte mode (fifo_en=0): rxrdy_n is 0 when rhr_full=1 and 1 when rhr_full=0.
- R3: Byte mode: txrdy_n is 0 when thr_empty=1 and 1 when thr_empty=0.
- R4: Stream mode (fifo_en=1, dma_mode=0): rxrdy_n is 0 when rx_count is 1 or more and 1 when rx_count is 0.
- R5: Stream mode: txrdy_n is 0 only when tx_count is 0.
- R6: Block mode (fifo_en=1, dma_mode=1): the *arm* transition sets rxrdy_n to 0 when rx_count is at least the trigger level. The rx_trig_sel encoding is 2'b00 for 1, 2'b01 for 4, 2'b10 for 8 and 2'b11 for 14 bytes.
- R7: Block mode: a one-cycle rx_timeout pulse also arms the latch, even when rx_count is below the trigger level.
- R8: Block mode: once rxrdy_n is 0 it stays 0 while rx_count is nonzero, even if rx_count falls below the trigger level. It returns to 1 only on *drain* (rx_count = 0).
- R9: Block mode: txrdy_n is 1 when tx_count is 16 and 0 when tx_count is below 16.
- R10: The *disarm* transition returns the latch to RX_IDLE on an rx_fifo_clr pulse and on any change of the {fifo_en, dma_mode} pair.
- R11: Each output reflects the inputs present at a rising clock edge starting from that edge. An input change between edges has no effect on the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | FIFO enable control bit |
| dma_mode | input | 1 | DMA block-mode select bit |
| rx_trig_sel | input | 2 | Receive trigger level code |
| rx_count | input | 5 | Receive FIFO fill level, 0 to 16 |
| tx_count | input | 5 | Transmit FIFO fill level, 0 to 16 |
| rhr_full | input | 1 | Receive holding register holds a byte (byte mode) |
| thr_empty | input | 1 | Transmit holding register is empty (byte mode) |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| rx_fifo_clr | input | 1 | One-cycle receive FIFO clear pulse |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low |

## Verification
Every output is due exactly one rising edge after the inputs that cause it, and that includes the block-mode latch. The latch's next state and the output register are updated at the same edge. The bench changes inputs on falling edges. A behavioural model updates at each rising edge, and the outputs are compared with it at the following falling edge, so each comparison sees the result of exactly one edge. A dedicated R11 check changes an input, samples the output one time unit later to confirm that it has not moved, and then samples it again after the next edge.

// File: rtl/dmardy_pkg.sv
package dmardy_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE   = 2'd0,
        MODE_STREAM = 2'd1,
        MODE_BLOCK  = 2'd2
    } ready_mode_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_HELD = 1'b1
    } rx_hold_e;

    function automatic int trig_level(input logic [1:0] sel);
        int lvl;
        unique case (sel)
            2'b00:   lvl = 1;
            2'b01:   lvl = 4;
            2'b10:   lvl = 8;
            default: lvl = 14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/dmardy_mode_trk.sv
module dmardy_mode_trk
    import dmardy_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_en,
    input  logic        dma_mode,
    output ready_mode_e mode,
    output logic        mode_chg
);

    ready_mode_e prev_q;

    always_comb begin
        if (!fifo_en)
            mode = MODE_BYTE;
        else if (dma_mode)
            mode = MODE_BLOCK;
        else
            mode = MODE_STREAM;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= MODE_BYTE;
        else
            prev_q <= mode;
    end

    assign mode_chg = (mode != prev_q);

endmodule

// File: rtl/dmardy_rx_fsm.sv
module dmardy_rx_fsm
    import dmardy_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       rx_trig_sel,
    input  logic             rx_timeout,
    output logic             hold_d
);

    rx_hold_e         state_q;
    rx_hold_e         state_d;
    logic [CNT_W-1:0] trig;

    assign trig = CNT_W'(trig_level(rx_trig_sel));

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RX_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (arm_en && ((rx_count >= trig) || rx_timeout))
                         state_d = RX_HELD;
            RX_HELD: if (!arm_en || (rx_count == '0))
                         state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    assign hold_d = (state_d == RX_HELD);

    // R10
    disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_en |=> (state_q == RX_IDLE));

endmodule

// File: rtl/uart_dma_ready_gen.sv
module uart_dma_ready_gen
    import dmardy_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_mode,
    input  logic [1:0]       rx_trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rhr_full,
    input  logic             thr_empty,
    input  logic             rx_timeout,
    input  logic             rx_fifo_clr,
    output logic             rxrdy_n,
    output logic             txrdy_n
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    ready_mode_e mode;
    logic        mode_chg;
    logic        arm_en;
    logic        hold_d;

    dmardy_mode_trk u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .dma_mode (dma_mode),
        .mode     (mode),
        .mode_chg (mode_chg)
    );

    assign arm_en = (mode == MODE_BLOCK) && !mode_chg && !rx_fifo_clr;

    dmardy_rx_fsm #(.CNT_W(CNT_W)) u_rx_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_en      (arm_en),
        .rx_count    (rx_count),
        .rx_trig_sel (rx_trig_sel),
        .rx_timeout  (rx_timeout),
        .hold_d      (hold_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxrdy_n <= 1'b1;
            txrdy_n <= 1'b1;
        end else begin
            unique case (mode)
                MODE_BYTE: begin
                    rxrdy_n <= !rhr_full;
                    txrdy_n <= !thr_empty;
                end
                MODE_STREAM: begin
                    rxrdy_n <= (rx_count == '0);
                    txrdy_n <= (tx_count != '0);
                end
                MODE_BLOCK: begin
                    rxrdy_n <= !hold_d;
                    txrdy_n <= (tx_count >= FULL_CNT);
                end
                default: begin
                    rxrdy_n <= 1'b1;
                    txrdy_n <= 1'b1;
                end
            endcase
        end
    end

    // R3
    byte_tx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && thr_empty) |=> !txrdy_n);

    // R4
    stream_rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !dma_mode && rx_count != '0) |=> !rxrdy_n);

    // R8
    block_rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && dma_mode && $stable(fifo_en) && $stable(dma_mode) &&
         !rxrdy_n && rx_count != '0 && !rx_fifo_clr) |=> !rxrdy_n);

    // R8
    block_rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && dma_mode && rx_count == '0 && !rx_timeout) |=> rxrdy_n);

    // R9
    block_tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && dma_mode && tx_count >= FULL_CNT) |=> txrdy_n);

endmodule

// File: tb/tb_uart_dma_ready_gen.sv
module tb_uart_dma_ready_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       dma_mode = 1'b0;
    logic [1:0] rx_trig_sel = 2'b00;
    logic [4:0] rx_count = '0;
    logic [4:0] tx_count = '0;
    logic       rhr_full = 1'b0;
    logic       thr_empty = 1'b0;
    logic       rx_timeout = 1'b0;
    logic       rx_fifo_clr = 1'b0;
    logic       rxrdy_n;
    logic       txrdy_n;

    int    vectors = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_rx = 1'b1;
    bit m_tx = 1'b1;
    bit m_hold = 1'b0;
    int m_prev = 0;
    int m_md;

    always #10 clk = ~clk;

    uart_dma_ready_gen dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .rx_trig_sel(rx_trig_sel), .rx_count(rx_count), .tx_count(tx_count),
        .rhr_full(rhr_full), .thr_empty(thr_empty), .rx_timeout(rx_timeout),
        .rx_fifo_clr(rx_fifo_clr), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
    );

    function automatic int level_of(input logic [1:0] s);
        if (s == 2'b00) return 1;
        if (s == 2'b01) return 4;
        if (s == 2'b10) return 8;
        return 14;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rx = 1'b1; m_tx = 1'b1; m_hold = 1'b0; m_prev = 0;
        end else begin
            m_md = !fifo_en ? 0 : (dma_mode ? 2 : 1);
            if (m_md != 2 || m_md != m_prev || rx_fifo_clr)
                m_hold = 1'b0;
            else if (m_hold && rx_count == 0)
                m_hold = 1'b0;
            else if (!m_hold && (int'(rx_count) >= level_of(rx_trig_sel) || rx_timeout))
                m_hold = 1'b1;
            if (m_md == 0) begin
                m_rx = !rhr_full; m_tx = !thr_empty;
            end else if (m_md == 1) begin
                m_rx = (rx_count == 0); m_tx = (tx_count != 0);
            end else begin
                m_rx = !m_hold; m_tx = (tx_count >= 16);
            end
            m_prev = m_md;
        end
    end

    task automatic check_bit(input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_bit("rxrdy_n", rxrdy_n, m_rx);
        check_bit("txrdy_n", txrdy_n, m_tx);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        ticks(3);
        check_bit("rxrdy_n reset", rxrdy_n, 1'b1);
        check_bit("txrdy_n reset", txrdy_n, 1'b1);
        rst_n = 1'b1;
        tick();

        // R2 / R3: byte mode
        cur_req = "R2";
        rhr_full = 1'b1; tick();
        check_bit("R2 rx low with byte", rxrdy_n, 1'b0);
        rhr_full = 1'b0; tick();
        check_bit("R2 rx high no byte", rxrdy_n, 1'b1);
        cur_req = "R3";
        thr_empty = 1'b1; tick();
        check_bit("R3 tx low when empty", txrdy_n, 1'b0);
        thr_empty = 1'b0; tick();
        check_bit("R3 tx high when loaded", txrdy_n, 1'b1);

        // R11: no change between edges
        cur_req = "R11";
        rhr_full = 1'b1;
        #1 check_bit("R11 rx stable before edge", rxrdy_n, 1'b1);
        tick();
        check_bit("R11 rx after edge", rxrdy_n, 1'b0);
        rhr_full = 1'b0; tick();

        // R4 / R5: stream mode
        fifo_en = 1'b1;
        cur_req = "R4";
        foreach (rx_pattern[i]) begin
            rx_count = rx_pattern[i]; tick();
        end
        cur_req = "R5";
        tx_count = 5'd0; tick();
        check_bit("R5 tx low empty", txrdy_n, 1'b0);
        tx_count = 5'd1; tick();
        check_bit("R5 tx high one", txrdy_n, 1'b1);
        tx_count = 5'd16; tick();
        tx_count = 5'd0; rx_count = 5'd0; tick();

        // R6 / R8: block mode, each trigger code
        dma_mode = 1'b1;
        tick();
        for (int s = 0; s < 4; s++) begin
            rx_trig_sel = 2'(s);
            cur_req = "R6";
            for (int c = 0; c <= level_of(2'(s)); c++) begin
                rx_count = 5'(c); tick();
            end
            check_bit("R6 rx low at trigger", rxrdy_n, 1'b0);
            cur_req = "R8";
            rx_count = 5'd1; tick();
            check_bit("R8 rx held below trigger", rxrdy_n, 1'b0);
            rx_count = 5'd0; tick();
            check_bit("R8 rx released on drain", rxrdy_n, 1'b1);
        end

        // R7: timeout
        cur_req = "R7";
        rx_trig_sel = 2'b11; rx_count = 5'd2; tick();
        check_bit("R7 below trigger idle", rxrdy_n, 1'b1);
        rx_timeout = 1'b1; tick();
        rx_timeout = 1'b0;
        check_bit("R7 timeout arms", rxrdy_n, 1'b0);
        ticks(2);
        rx_count = 5'd0; tick();

        // R9: block-mode transmit
        cur_req = "R9";
        tx_count = 5'd15; tick();
        check_bit("R9 tx low with room", txrdy_n, 1'b0);
        tx_count = 5'd16; tick();
        check_bit("R9 tx high full", txrdy_n, 1'b1);
        tx_count = 5'd3; tick();

        // R10: clear pulse and mode change
        cur_req = "R10";
        rx_trig_sel = 2'b10; rx_count = 5'd8; tick();
        rx_count = 5'd5; tick();
        check_bit("R10 held before clear", rxrdy_n, 1'b0);
        rx_fifo_clr = 1'b1; tick();
        rx_fifo_clr = 1'b0;
        check_bit("R10 clear releases", rxrdy_n, 1'b1);
        ticks(2);
        rx_count = 5'd9; tick();
        rx_count = 5'd5; tick();
        dma_mode = 1'b0; tick();
        dma_mode = 1'b1; tick();
        check_bit("R10 mode change releases", rxrdy_n, 1'b1);
        ticks(2);

        // R1: reset in the middle of block mode
        cur_req = "R1";
        rx_count = 5'd9; tick();
        rst_n = 1'b0; tick();
        check_bit("R1 reset releases", rxrdy_n, 1'b1);
        rst_n = 1'b1; ticks(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    int rx_pattern [5] = '{0, 1, 5, 16, 0};

endmodule